// File: doc/BRIEF.md
# I2C Target Receive Event Queue

This block sits between a bit-level I2C target engine and the software that consumes received write data. The engine reports address phases, received data bytes, repeated starts and stops. The block keeps track of which of its two own addresses the current transfer selected, decides whether each data byte is acknowledged, and stores every accepted event in an ordered queue. Each queue entry holds a byte and a 7-bit tag that records how the byte arrived.

Stop and repeated-start events get entries of their own, with a dummy byte of zero, so software sees bus context in order with the data. The tag of the oldest entry is always visible on the head outputs. A one-cycle read strobe removes that entry. Two status bits tell software that the queue holds entries and that a write transfer has ended. Each bit is gated by its own enable.

Top module: `tgt_rx_evq`

## Requirements
- R1: An address event is acknowledged (`addr_ack`=1 in the same cycle) only if an enabled own address matches it. `dec_ctl[0]` enables address 1 and `dec_ctl[1]` selects 10-bit matching for it. `dec_ctl[2]` and `dec_ctl[3]` do the same for address 2. In 7-bit mode a match needs `ev_addr_ten`=0 and equal bits 6:0. In 10-bit mode it needs `ev_addr_ten`=1 and all 10 bits equal.
- R2: When both addresses match, address 1 owns the transfer.
- R3: A data byte in a matched transfer is stored with tag bit 0 set (address 1) or tag bit 1 set (address 2). While at least two slots are free, the byte is acknowledged if `rx_ack_en[0]` (address 1) or `rx_ack_en[1]` (address 2) is set. The ACK decision is shown on `data_ack` in the same cycle and recorded in tag bit 2.
- R4: Tag bit 4 is set only on the first data entry stored after a matched address event.
- R5: In a matched transfer, a repeated start stores an entry with tag 0x20 and a stop stores an entry with tag 0x40. Both carry data 0x00. A stop ends the transfer.
- R6: The head outputs show the oldest entry, and entries leave in arrival order. A pop removes the head one cycle after it is strobed. A pop on an empty queue has no effect.
- R7: With one slot free, a data byte is NACKed and stored with tag bit 3 set and bit 2 clear. With no slot free, every event is dropped. The fill level never exceeds DEPTH (default 8).
- R8: `tgt_status[0]` equals the queue being non-empty AND `irq_en[0]`.
- R9: `tgt_status[1]` is set by a stop that ends a matched transfer and held until a `wc_clr` pulse. It is gated by `irq_en[1]`.
- R10: Data, repeated-start and stop events outside a matched transfer change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_addr1 | input | 10 | Own address 1 |
| own_addr2 | input | 10 | Own address 2 |
| dec_ctl | input | 4 | Address enables and 10-bit mode selects |
| rx_ack_en | input | 2 | ACK enable for write data, per address |
| irq_en | input | 2 | Status bit enables |
| ev_addr_valid | input | 1 | Address phase event strobe |
| ev_addr | input | 10 | Received address |
| ev_addr_ten | input | 1 | Address was received in 10-bit form |
| addr_ack | output | 1 | Acknowledge the address event |
| ev_data_valid | input | 1 | Data byte event strobe |
| ev_data | input | 8 | Received byte |
| data_ack | output | 1 | Acknowledge the data byte |
| ev_rstart | input | 1 | Repeated start event strobe |
| ev_stop | input | 1 | Stop event strobe |
| rd_pop | input | 1 | Data read strobe that pops the head |
| head_flags | output | 7 | Tag of the head entry |
| head_data | output | 8 | Byte of the head entry |
| fifo_level | output | 4 | Number of stored entries |
| wc_clr | input | 1 | Clears the write-complete status |
| tgt_status | output | 2 | {write complete, queue needs service} |

## Verification
`addr_ack` and `data_ack` are combinational replies, so they are due in the cycle the event is held. The bench drives events on the falling edge and samples the replies a step later in that same half cycle. New entries, level and status appear after the next rising edge, and a pop takes effect at the rising edge after the strobe. Every such value is sampled at the following falling edge. A scoreboard queue holds the expected entries in order. A drain task compares the head against the front of the queue before each pop strobe.

// File: rtl/tgt_rx_pkg.sv
package tgt_rx_pkg;
  localparam int FLAG_W   = 7;
  localparam int BYTE_W   = 8;
  localparam int ADDR_W   = 10;
  localparam int NUM_ADDR = 2;

  // tag bit positions, decoded by software
  localparam int F_DV1   = 0;
  localparam int F_DV2   = 1;
  localparam int F_ACK   = 2;
  localparam int F_OVNAK = 3;
  localparam int F_FIRST = 4;
  localparam int F_RSTRT = 5;
  localparam int F_STOP  = 6;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [BYTE_W-1:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    SESS_NONE = 2'd0,
    SESS_A1   = 2'd1,
    SESS_A2   = 2'd2
  } sess_e;
endpackage

// File: rtl/tgt_addr_match.sv
module tgt_addr_match
  import tgt_rx_pkg::*;
(
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_addr_ten,
  input  logic [ADDR_W-1:0] own_addr1,
  input  logic [ADDR_W-1:0] own_addr2,
  input  logic [3:0]        dec_ctl,
  output logic [NUM_ADDR-1:0] hit
);
  logic [NUM_ADDR-1:0][ADDR_W-1:0] own;
  assign own[0] = own_addr1;
  assign own[1] = own_addr2;

  for (genvar g = 0; g < NUM_ADDR; g++) begin : g_slot
    logic en, ten_mode, eq7, eq10;
    assign en       = dec_ctl[2*g];
    assign ten_mode = dec_ctl[2*g+1];
    assign eq7      = !ev_addr_ten && (ev_addr[6:0] == own[g][6:0]);
    assign eq10     = ev_addr_ten && (ev_addr == own[g]);
    assign hit[g]   = en && (ten_mode ? eq10 : eq7);
  end
endmodule

// File: rtl/tgt_rx_ctrl.sv
module tgt_rx_ctrl
  import tgt_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_ADDR-1:0] hit,
  input  logic [1:0]          rx_ack_en,
  input  logic [1:0]          irq_en,
  input  logic                ev_addr_valid,
  input  logic                ev_data_valid,
  input  logic [BYTE_W-1:0]   ev_data,
  input  logic                ev_rstart,
  input  logic                ev_stop,
  input  logic                wc_clr,
  input  logic [CW-1:0]       level,
  output logic                addr_ack,
  output logic                data_ack,
  output logic                push,
  output rx_entry_t           entry,
  output logic [1:0]          status
);
  sess_e sess_q, sess_d;
  logic  first_q, first_d;
  logic  wc_q, wc_d;
  logic  room1, room2, ack_en, wc_set;

  assign room1  = level < CW'(DEPTH);
  assign room2  = level < CW'(DEPTH - 1);
  assign ack_en = (sess_q == SESS_A1) ? rx_ack_en[0] : rx_ack_en[1];

  always_comb begin
    sess_d   = sess_q;
    first_d  = first_q;
    push     = 1'b0;
    entry    = '0;
    addr_ack = 1'b0;
    data_ack = 1'b0;
    wc_set   = 1'b0;
    if (ev_addr_valid) begin
      addr_ack = |hit;
      first_d  = |hit;
      if (hit[0])      sess_d = SESS_A1;
      else if (hit[1]) sess_d = SESS_A2;
      else             sess_d = SESS_NONE;
    end else if (sess_q != SESS_NONE) begin
      if (ev_data_valid) begin
        entry.data         = ev_data;
        entry.flags[F_DV1]   = (sess_q == SESS_A1);
        entry.flags[F_DV2]   = (sess_q == SESS_A2);
        entry.flags[F_FIRST] = first_q;
        if (room2) begin
          push                = 1'b1;
          data_ack            = ack_en;
          entry.flags[F_ACK]  = ack_en;
        end else if (room1) begin
          push                 = 1'b1;
          entry.flags[F_OVNAK] = 1'b1;
        end
        if (push) first_d = 1'b0;
      end else if (ev_rstart) begin
        push                 = room1;
        entry.flags[F_RSTRT] = 1'b1;
      end else if (ev_stop) begin
        push                = room1;
        entry.flags[F_STOP] = 1'b1;
        sess_d              = SESS_NONE;
        first_d             = 1'b0;
        wc_set              = 1'b1;
      end
    end
  end

  always_comb begin
    wc_d = wc_q;
    if (wc_clr) wc_d = 1'b0;
    if (wc_set) wc_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sess_q  <= SESS_NONE;
      first_q <= 1'b0;
      wc_q    <= 1'b0;
    end else begin
      sess_q  <= sess_d;
      first_q <= first_d;
      wc_q    <= wc_d;
    end
  end

  assign status[0] = (level != '0) && irq_en[0];
  assign status[1] = wc_q && irq_en[1];

  // R4: the first-byte tag is consumed by the entry that carries it
  a_r4_first_once: assert property (@(posedge clk) disable iff (!rst_n)
    (push && entry.flags[F_FIRST] && !ev_addr_valid) |=> !first_q);
  // R5: a stop in a matched transfer closes it
  a_r5_stop_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_addr_valid && !ev_data_valid && !ev_rstart && sess_q != SESS_NONE)
      |=> (sess_q == SESS_NONE));
  // R10: no push without a matched transfer
  a_r10_no_stray_push: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (sess_q != SESS_NONE));
endmodule

// File: rtl/tgt_evt_fifo.sv
module tgt_evt_fifo
  import tgt_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push_i,
  input  rx_entry_t entry_i,
  input  logic      pop_i,
  output rx_entry_t head_o,
  output logic [CW-1:0] count_o
);
  rx_entry_t     slot_q [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_eff;

  assign pop_eff = pop_i && (cnt_q != '0);

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push_i) wr_d = (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (pop_eff) rd_d = (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    case ({push_i, pop_eff})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push_i && (wr_q == PW'(i))) slot_q[i] <= entry_i;
    end
  end

  assign head_o  = (cnt_q != '0) ? slot_q[rd_q] : '0;
  assign count_o = cnt_q;

  // R7: level bounded by depth
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
  // R7: controller never pushes into a full queue
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) |-> !push_i);
  // R6: pop on empty leaves the queue empty
  a_r6_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && cnt_q == '0 && !push_i) |=> (cnt_q == '0));
endmodule

// File: rtl/tgt_rx_evq.sv
module tgt_rx_evq
  import tgt_rx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr1,
  input  logic [ADDR_W-1:0] own_addr2,
  input  logic [3:0]        dec_ctl,
  input  logic [1:0]        rx_ack_en,
  input  logic [1:0]        irq_en,
  input  logic              ev_addr_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_addr_ten,
  output logic              addr_ack,
  input  logic              ev_data_valid,
  input  logic [BYTE_W-1:0] ev_data,
  output logic              data_ack,
  input  logic              ev_rstart,
  input  logic              ev_stop,
  input  logic              rd_pop,
  output logic [FLAG_W-1:0] head_flags,
  output logic [BYTE_W-1:0] head_data,
  output logic [CW-1:0]     fifo_level,
  input  logic              wc_clr,
  output logic [1:0]        tgt_status
);
  logic [1:0]          rst_sync_q;
  logic                rst_int_n;
  logic [NUM_ADDR-1:0] hit;
  logic                push;
  rx_entry_t           entry, head;
  logic [CW-1:0]       level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tgt_addr_match u_match (
    .ev_addr     (ev_addr),
    .ev_addr_ten (ev_addr_ten),
    .own_addr1   (own_addr1),
    .own_addr2   (own_addr2),
    .dec_ctl     (dec_ctl),
    .hit         (hit)
  );

  tgt_rx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_int_n),
    .hit           (hit),
    .rx_ack_en     (rx_ack_en),
    .irq_en        (irq_en),
    .ev_addr_valid (ev_addr_valid),
    .ev_data_valid (ev_data_valid),
    .ev_data       (ev_data),
    .ev_rstart     (ev_rstart),
    .ev_stop       (ev_stop),
    .wc_clr        (wc_clr),
    .level         (level),
    .addr_ack      (addr_ack),
    .data_ack      (data_ack),
    .push          (push),
    .entry         (entry),
    .status        (tgt_status)
  );

  tgt_evt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .push_i  (push),
    .entry_i (entry),
    .pop_i   (rd_pop),
    .head_o  (head),
    .count_o (level)
  );

  assign head_flags = head.flags;
  assign head_data  = head.data;
  assign fifo_level = level;

  // R3: an ACKed byte always leaves at least one slot spare
  a_r3_ack_room: assert property (@(posedge clk) disable iff (!rst_int_n)
    data_ack |-> (level < CW'(DEPTH - 1)));
  // R1: no address ACK while both addresses are disabled
  a_r1_ack_enabled: assert property (@(posedge clk) disable iff (!rst_int_n)
    addr_ack |-> (dec_ctl[0] || dec_ctl[2]));
endmodule

// File: tb/tgt_rx_evq_bench.sv
module tgt_rx_evq_bench;
  logic       clk, rst_n;
  logic [9:0] own_addr1, own_addr2, ev_addr;
  logic [3:0] dec_ctl;
  logic [1:0] rx_ack_en, irq_en, tgt_status;
  logic       ev_addr_valid, ev_addr_ten, addr_ack;
  logic       ev_data_valid, data_ack, ev_rstart, ev_stop, rd_pop, wc_clr;
  logic [7:0] ev_data, head_data;
  logic [6:0] head_flags;
  logic [3:0] fifo_level;

  int ntests = 0;
  int nfail  = 0;
  logic [14:0] sb [$];

  tgt_rx_evq u_tgt_rx_evq (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string req, int act, int exp);
    ntests++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_addr(logic [9:0] a, logic ten, int exp, string req);
    @(negedge clk);
    ev_addr = a; ev_addr_ten = ten; ev_addr_valid = 1'b1;
    #1 check(req, int'(addr_ack), exp);
    @(negedge clk);
    ev_addr_valid = 1'b0;
  endtask

  task automatic do_data(logic [7:0] d, int exp_ack, bit stored, logic [6:0] fl, string req);
    @(negedge clk);
    ev_data = d; ev_data_valid = 1'b1;
    #1 check(req, int'(data_ack), exp_ack);
    if (stored) sb.push_back({fl, d});
    @(negedge clk);
    ev_data_valid = 1'b0;
  endtask

  task automatic do_evt(bit rs, bit stored, string req);
    @(negedge clk);
    ev_rstart = rs; ev_stop = !rs;
    if (stored) sb.push_back({rs ? 7'h20 : 7'h40, 8'h00});
    @(negedge clk);
    ev_rstart = 1'b0; ev_stop = 1'b0;
  endtask

  task automatic chk_level(int exp, string req);
    @(negedge clk);
    check(req, int'(fifo_level), exp);
  endtask

  // monitor: compare head against scoreboard, then pop
  task automatic drain(string req);
    while (sb.size() != 0) begin
      logic [14:0] e;
      e = sb.pop_front();
      @(negedge clk);
      check({req, " flags"}, int'(head_flags), int'(e[14:8]));
      check({req, " data"},  int'(head_data),  int'(e[7:0]));
      rd_pop = 1'b1;
      @(negedge clk);
      rd_pop = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    own_addr1 = 10'h02A; own_addr2 = 10'h3A5; dec_ctl = 4'b1101;
    rx_ack_en = 2'b11; irq_en = 2'b11;
    ev_addr_valid = 0; ev_addr = 0; ev_addr_ten = 0; ev_data_valid = 0;
    ev_data = 0; ev_rstart = 0; ev_stop = 0; rd_pop = 0; wc_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 reset level", int'(fifo_level), 0);
    check("R8 reset status", int'(tgt_status), 0);

    // basic write to address 1
    do_addr(10'h02A, 0, 1, "R1 7-bit match");
    do_data(8'h11, 1, 1, 7'h15, "R3 ack first");
    do_data(8'h22, 1, 1, 7'h05, "R4 ack second");
    chk_level(2, "R6 level two");
    check("R8 service set", int'(tgt_status[0]), 1);
    irq_en = 2'b00;
    #1 check("R8 service gated", int'(tgt_status), 0);
    irq_en = 2'b11;
    do_evt(0, 1, "R5 stop");
    #1 check("R9 write complete", int'(tgt_status[1]), 1);
    drain("R6 order");
    check("R8 service clear", int'(tgt_status[0]), 0);
    @(negedge clk); wc_clr = 1'b1; @(negedge clk); wc_clr = 1'b0;
    check("R9 cleared", int'(tgt_status[1]), 0);

    // not addressed
    do_addr(10'h02B, 0, 0, "R1 mismatch");
    do_data(8'h33, 0, 0, 7'h00, "R10 stray data");
    do_evt(1, 0, "R10 stray rstart");
    do_evt(0, 0, "R10 stray stop");
    chk_level(0, "R10 nothing stored");
    check("R10 no write complete", int'(tgt_status[1]), 0);

    // address 2, 10-bit
    do_addr(10'h3A5, 1, 1, "R1 10-bit match");
    do_data(8'h44, 1, 1, 7'h16, "R3 addr2 ack");
    rx_ack_en = 2'b01;
    do_data(8'h55, 0, 1, 7'h02, "R3 addr2 nack");
    rx_ack_en = 2'b11;
    do_addr(10'h025, 0, 0, "R1 7-bit form of 10-bit address");
    do_addr(10'h02A, 1, 0, "R1 10-bit form vs 7-bit address");

    // repeated start
    do_addr(10'h02A, 0, 1, "R1 rematch");
    do_evt(1, 1, "R5 rstart entry");
    do_addr(10'h02A, 0, 1, "R1 after rstart");
    do_data(8'h66, 1, 1, 7'h15, "R4 first after rstart");
    do_evt(0, 1, "R5 stop entry");
    drain("R5 context");

    // priority
    own_addr2 = 10'h02A; dec_ctl = 4'b0101;
    do_addr(10'h02A, 0, 1, "R2 both match");
    do_data(8'h77, 1, 1, 7'h15, "R2 addr1 wins");
    dec_ctl = 4'b0100;
    do_addr(10'h02A, 0, 1, "R1 addr2 only");
    do_data(8'h78, 1, 1, 7'h16, "R2 addr2 when addr1 off");
    dec_ctl = 4'b0000;
    do_addr(10'h02A, 0, 0, "R1 all disabled");
    own_addr2 = 10'h3A5; dec_ctl = 4'b1101;
    drain("R2 entries");
    @(negedge clk); wc_clr = 1'b1; @(negedge clk); wc_clr = 1'b0;

    // fill to capacity
    do_addr(10'h02A, 0, 1, "R1 fill");
    for (int i = 0; i < 7; i++)
      do_data(8'h80 + 8'(i), 1, 1, (i == 0) ? 7'h15 : 7'h05, "R7 ack while room");
    do_data(8'h87, 0, 1, 7'h09, "R7 last slot nack");
    chk_level(8, "R7 full");
    do_data(8'h88, 0, 0, 7'h00, "R7 dropped");
    do_evt(0, 0, "R7 stop dropped");
    chk_level(8, "R7 still full");
    drain("R7 contents");
    @(negedge clk); wc_clr = 1'b1; @(negedge clk); wc_clr = 1'b0;

    // pop on empty
    @(negedge clk); rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0;
    chk_level(0, "R6 pop empty");
    do_addr(10'h02A, 0, 1, "R1 final");
    do_data(8'h99, 1, 1, 7'h15, "R6 after empty pop");
    chk_level(1, "R6 level one");
    drain("R6 final");

    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule